// File: doc/BRIEF.md
# Opcode Fetch M1 Strobe Controller

This block sits between a processor core and its external memory bus. It runs each machine cycle that the core requests as three clock states (T1, T2, T3) and drives the address, the memory-request strobe, the read strobe and the machine-cycle-one (M1) strobe on the bus. A one-byte mode register, reached through an internal I/O address, selects whether M1 is driven during ordinary opcode fetches.

When the M1-enable bit is clear, ordinary opcode fetches leave M1 high. External peripherals that decode the two-byte return-from-interrupt opcode (ED then 4D) still need to see it under M1. So the block watches consecutive opcode bytes. When it sees ED followed by 4D at the next address, it replays both fetches with M1, MREQ and RD low, and places idle states around the replay. The core is held off during the replay and only sees the bytes of the first pass.

Top module: `m1_strobe_ctl`

## Requirements
- R1: The mode register sits at I/O address 0x3E. Bit 7 is the M1-enable bit (read/write). Bit 5 is the compatibility bit (read/write), which drives `mode_compat`. Bit 6 may be written but reads back 0, and bits 4..0 read 0. A read of any other address returns 0, and a write to any other address changes nothing.
- R2: After reset, the mode register reads 0x80: M1-enable is 1 and the compatibility bit is 0. While idle, all three strobes are high, `bus_addr` is 0 and `rvalid` is 0.
- R3: Cycle types are encoded on `req_type` as 00 opcode fetch, 01 memory read, 10 interrupt acknowledge, 11 NMI acknowledge first cycle. Every machine cycle lasts exactly three clocks with `bus_addr` held at the requested address. Opcode fetch, memory read and NMI acknowledge drive MREQ and RD low in all three clocks. `rvalid` is high in the third clock, with `rdata` equal to the bus byte.
- R4: With M1-enable at 1, M1 is low in all three clocks of an opcode fetch. M1 stays high during a memory read.
- R5: Interrupt acknowledge and NMI acknowledge cycles drive M1 low whatever the M1-enable bit holds. An interrupt acknowledge leaves MREQ and RD high.
- R6: With M1-enable at 0, M1 stays high during ordinary opcode fetches.
- R7: With M1-enable at 0, the replay is triggered by an opcode fetch of ED at address A directly followed by an opcode fetch of 4D at A+1. After the third clock of the 4D fetch come two idle clocks. Then three clocks at A with M1, MREQ and RD low, one idle clock, three clocks at A+1 likewise, and one idle clock. `rvalid` stays 0 throughout the replay.
- R8: `req_ready` is low from the third clock of the triggering 4D fetch until the final idle clock of the replay has passed. The next request starts only after that.
- R9: No replay happens in these cases: ED followed by a byte other than 4D; ED followed by 4D at a non-consecutive address; a memory read between the two fetches; or M1-enable at 1.
- R10: A request presented during the third clock of a cycle that does not trigger a replay starts its T1 on the next clock, with no idle clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents a machine-cycle request |
| req_type | input | 2 | Cycle type (see R3) |
| req_addr | input | AW | Cycle address |
| req_ready | output | 1 | Request accepted at this clock edge when valid |
| rvalid | output | 1 | Read byte available (third clock) |
| rdata | output | 8 | Byte read from the bus |
| bus_addr | output | AW | External address |
| bus_data_in | input | 8 | External data bus (read direction) |
| mreq_n | output | 1 | Memory request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| m1_n | output | 1 | Machine-cycle-one strobe, active low |
| io_addr | input | 8 | Internal I/O register address |
| io_wr | input | 1 | Register write strobe |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Register read data |
| mode_compat | output | 1 | Compatibility bit of the mode register |

## Verification
Opcode fetches, memory reads and both acknowledge types are run with M1-enable set and then clear. This separates the enable-gated M1 of fetches from the always-driven M1 of acknowledges. The ED 4D pair is fetched in both modes, so the replay is shown to depend on the mode bit. Three near-miss patterns are also fetched: ED 45, ED and 4D at addresses that are not adjacent, and ED with a memory read before the 4D. Each of these would expose a detector that arms too loosely. Back-to-back requests show that cycles follow one another with no idle clock, and that the core is held off for exactly the replay window.

// File: rtl/m1s_pkg.sv
package m1s_pkg;
  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_MEMRD = 2'b01,
    CYC_INTA  = 2'b10,
    CYC_NMIA  = 2'b11
  } cyc_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_T1, ST_T2, ST_T3, ST_GAPA, ST_GAPB,
    ST_R1, ST_R2, ST_R3, ST_RI
  } st_e;

  localparam logic [7:0] OPC_PREFIX = 8'hED;
  localparam logic [7:0] OPC_RETI   = 8'h4D;
endpackage

// File: rtl/m1s_modereg.sv
module m1s_modereg #(
  parameter int IOW = 8,
  parameter logic [IOW-1:0] MODE_ADDR = 8'h3E
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IOW-1:0] io_addr,
  input  logic           io_wr,
  input  logic [7:0]     io_wdata,
  output logic [7:0]     io_rdata,
  output logic           m1e_o,
  output logic           ioc_o
);
  logic m1e_q, m1e_d, ioc_q, ioc_d;
  logic sel;
  logic unused_wbits;

  assign sel          = (io_addr == MODE_ADDR);
  assign unused_wbits = ^{io_wdata[6], io_wdata[4:0]};

  always_comb begin
    m1e_d = m1e_q;
    ioc_d = ioc_q;
    if (io_wr && sel) begin
      m1e_d = io_wdata[7];
      ioc_d = io_wdata[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1e_q <= 1'b1;
      ioc_q <= 1'b0;
    end else begin
      m1e_q <= m1e_d;
      ioc_q <= ioc_d;
    end
  end

  assign io_rdata = sel ? {m1e_q, 1'b0, ioc_q, 5'b0} : 8'h00;
  assign m1e_o    = m1e_q;
  assign ioc_o    = ioc_q;

  // R1: a write to the mode address lands in the enable bit on the next clock
  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && sel) |=> (m1e_q == $past(io_wdata[7])));
endmodule

// File: rtl/m1s_rdet.sv
module m1s_rdet
  import m1s_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          t3_i,
  input  cyc_e          cyc_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic          m1e_i,
  output logic          hit_o,
  output logic [AW-1:0] base_o
);
  logic          armed_q, armed_d;
  logic [AW-1:0] base_q, base_d;
  logic          quiet_fetch;

  assign quiet_fetch = t3_i && (cyc_i == CYC_FETCH) && !m1e_i;
  assign hit_o = quiet_fetch && armed_q && (data_i == OPC_RETI) &&
                 (addr_i == AW'(base_q + 1'b1));

  always_comb begin
    armed_d = armed_q;
    base_d  = base_q;
    if (t3_i) begin
      armed_d = quiet_fetch && (data_i == OPC_PREFIX);
      if (armed_d) base_d = addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      base_q  <= '0;
    end else begin
      armed_q <= armed_d;
      base_q  <= base_d;
    end
  end

  assign base_o = base_q;

  // R9: a replay consumes the armed prefix
  a_r9_hit_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !armed_q);
endmodule

// File: rtl/m1s_seq.sv
module m1s_seq
  import m1s_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  cyc_e          req_type,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  input  logic          m1e_i,
  input  logic [7:0]    data_i,
  input  logic          hit_i,
  input  logic [AW-1:0] rep_base_i,
  output logic          t3_o,
  output cyc_e          cyc_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [AW-1:0] bus_addr,
  output logic          mreq_n,
  output logic          rd_n,
  output logic          m1_n,
  output logic          rvalid,
  output logic [7:0]    rdata
);
  st_e           st_q, st_d;
  cyc_e          cyc_q, cyc_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          rsel_q, rsel_d;
  logic          accept, in_norm, in_rep, mem_cyc, m1_norm;
  logic [AW-1:0] rep_addr;

  assign req_ready = (st_q == ST_IDLE) || ((st_q == ST_T3) && !hit_i);
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_d   = st_q;
    cyc_d  = cyc_q;
    addr_d = addr_q;
    rsel_d = rsel_q;
    if (accept) begin
      cyc_d  = req_type;
      addr_d = req_addr;
    end
    case (st_q)
      ST_IDLE: if (accept) st_d = ST_T1;
      ST_T1:   st_d = ST_T2;
      ST_T2:   st_d = ST_T3;
      ST_T3: begin
        if (hit_i)       st_d = ST_GAPA;
        else if (accept) st_d = ST_T1;
        else             st_d = ST_IDLE;
      end
      ST_GAPA: st_d = ST_GAPB;
      ST_GAPB: begin
        st_d   = ST_R1;
        rsel_d = 1'b0;
      end
      ST_R1:   st_d = ST_R2;
      ST_R2:   st_d = ST_R3;
      ST_R3:   st_d = ST_RI;
      ST_RI: begin
        if (!rsel_q) begin
          st_d   = ST_R1;
          rsel_d = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cyc_q  <= CYC_FETCH;
      addr_q <= '0;
      rsel_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cyc_q  <= cyc_d;
      addr_q <= addr_d;
      rsel_q <= rsel_d;
    end
  end

  assign in_norm  = (st_q == ST_T1) || (st_q == ST_T2) || (st_q == ST_T3);
  assign in_rep   = (st_q == ST_R1) || (st_q == ST_R2) || (st_q == ST_R3);
  assign rep_addr = rsel_q ? AW'(rep_base_i + 1'b1) : rep_base_i;
  assign mem_cyc  = (cyc_q != CYC_INTA);
  assign m1_norm  = ((cyc_q == CYC_FETCH) && m1e_i) ||
                    (cyc_q == CYC_INTA) || (cyc_q == CYC_NMIA);

  assign bus_addr   = in_norm ? addr_q : (in_rep ? rep_addr : '0);
  assign mreq_n     = !((in_norm && mem_cyc) || in_rep);
  assign rd_n       = !((in_norm && mem_cyc) || in_rep);
  assign m1_n       = !((in_norm && m1_norm) || in_rep);
  assign rvalid     = (st_q == ST_T3);
  assign rdata      = data_i;
  assign t3_o       = (st_q == ST_T3);
  assign cyc_o      = cyc_q;
  assign cur_addr_o = addr_q;

  // R3: three-state machine cycle order
  a_r3_t1_to_t2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_T1) |=> (st_q == ST_T2));
  a_r3_t2_to_t3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_T2) |=> (st_q == ST_T3));
  // R3: address held across a cycle
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_T2) || (st_q == ST_T3)) |-> $stable(bus_addr));
  // R7: two idle states lead into the replay of the prefix byte
  a_r7_gap_to_replay: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAPB) |=> ((st_q == ST_R1) && !rsel_q));
  // R7: prefix byte replayed before the second byte
  a_r7_byte_order: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RI) && !rsel_q) |=> ((st_q == ST_R1) && rsel_q));
endmodule

// File: rtl/m1_strobe_ctl.sv
module m1_strobe_ctl
  import m1s_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [7:0] MODE_ADDR = 8'h3E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_type,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          rvalid,
  output logic [7:0]    rdata,
  output logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_data_in,
  output logic          mreq_n,
  output logic          rd_n,
  output logic          m1_n,
  input  logic [7:0]    io_addr,
  input  logic          io_wr,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  output logic          mode_compat
);
  logic          m1e, hit, t3;
  logic [AW-1:0] base, cur_addr;
  cyc_e          cyc;

  m1s_modereg #(.IOW(8), .MODE_ADDR(MODE_ADDR)) u_mode (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .m1e_o(m1e), .ioc_o(mode_compat)
  );

  m1s_rdet #(.AW(AW)) u_det (
    .clk(clk), .rst_n(rst_n), .t3_i(t3), .cyc_i(cyc), .addr_i(cur_addr),
    .data_i(bus_data_in), .m1e_i(m1e), .hit_o(hit), .base_o(base)
  );

  m1s_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(cyc_e'(req_type)),
    .req_addr(req_addr), .req_ready(req_ready), .m1e_i(m1e),
    .data_i(bus_data_in), .hit_i(hit), .rep_base_i(base), .t3_o(t3),
    .cyc_o(cyc), .cur_addr_o(cur_addr), .bus_addr(bus_addr),
    .mreq_n(mreq_n), .rd_n(rd_n), .m1_n(m1_n), .rvalid(rvalid), .rdata(rdata)
  );
endmodule

// File: tb/m1_strobe_ctl_tb.sv
module m1_strobe_ctl_tb;
  localparam int PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [1:0] req_type;
  logic [AW-1:0] req_addr;
  logic req_ready, rvalid, mreq_n, rd_n, m1_n, mode_compat, io_wr;
  logic [7:0] rdata, bus_data_in, io_addr, io_wdata, io_rdata;
  logic [AW-1:0] bus_addr;
  logic [7:0] mem [0:255];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit bench_m1e = 1;

  typedef struct {
    logic m1, mreq, rd;
    logic [AW-1:0] a;
    logic rv;
    logic [7:0] d;
    string tag;
  } exp_t;
  exp_t q[$];

  always #(PERIOD/2) clk = ~clk;
  assign bus_data_in = mem[bus_addr[7:0]];

  m1_strobe_ctl #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_ready(req_ready), .rvalid(rvalid), .rdata(rdata),
    .bus_addr(bus_addr), .bus_data_in(bus_data_in), .mreq_n(mreq_n), .rd_n(rd_n),
    .m1_n(m1_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .mode_compat(mode_compat)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic exp_t mk(input logic m1, input logic mr, input logic rd,
                              input logic [AW-1:0] a, input logic rv, input string tag);
    exp_t e;
    e.m1 = m1; e.mreq = mr; e.rd = rd; e.a = a; e.rv = rv;
    e.d = mem[a[7:0]]; e.tag = tag;
    return e;
  endfunction

  // monitor: compares one bus state per clock, away from the edge
  always @(posedge clk) begin
    #(PERIOD/4);
    if (rst_n && !done) begin
      exp_t e;
      if (q.size() > 0) e = q.pop_front();
      else e = mk(1'b1, 1'b1, 1'b1, '0, 1'b0, "R2 idle");
      check({m1_n, mreq_n, rd_n, rvalid} == {e.m1, e.mreq, e.rd, e.rv} &&
            bus_addr == e.a && (!e.rv || rdata == e.d), e.tag,
            {rdata, 3'b0, m1_n, mreq_n, rd_n, rvalid, bus_addr},
            {e.d, 3'b0, e.m1, e.mreq, e.rd, e.rv, e.a});
    end
  end

  // driver: issues one machine cycle and pushes its expected waveform
  task automatic do_cyc(input logic [1:0] ty, input logic [AW-1:0] a,
                        input bit replay, input string tag);
    logic m1x, memx;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_type = ty; req_addr = a;
    m1x  = (ty == 2'b00) ? !bench_m1e : 1'b0;
    if (ty == 2'b01) m1x = 1'b1;
    memx = (ty == 2'b10);
    for (int t = 0; t < 3; t++) q.push_back(mk(m1x, memx, memx, a, t == 2, tag));
    if (replay) begin
      q.push_back(mk(1, 1, 1, '0, 0, "R7 gap"));
      q.push_back(mk(1, 1, 1, '0, 0, "R7 gap"));
      for (int t = 0; t < 3; t++) q.push_back(mk(0, 0, 0, a - 1, 0, "R7 replay A"));
      q.push_back(mk(1, 1, 1, '0, 0, "R7 gap"));
      for (int t = 0; t < 3; t++) q.push_back(mk(0, 0, 0, a, 0, "R7 replay A+1"));
      q.push_back(mk(1, 1, 1, '0, 0, "R8 gap"));
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic settle();
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    io_addr = a;
    #1 check(io_rdata == exp, tag, io_rdata, exp);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 1);
    mem[8'h10] = 8'hED; mem[8'h11] = 8'h4D;
    mem[8'h20] = 8'hED; mem[8'h21] = 8'h45;
    mem[8'h30] = 8'hED; mem[8'h31] = 8'h00; mem[8'h40] = 8'h4D;
    mem[8'h50] = 8'hED; mem[8'h51] = 8'h4D;
    rst_n = 1'b0; req_valid = 1'b0; req_type = '0; req_addr = '0;
    io_addr = '0; io_wr = 1'b0; io_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state of the mode register
    rd_reg(8'h3E, 8'h80, "R2 mode reset");
    check(mode_compat == 1'b0, "R2 compat reset", mode_compat, 0);
    // R1: register bit behaviour and address decode
    wr_reg(8'h3E, 8'hFF);
    rd_reg(8'h3E, 8'hA0, "R1 write all ones");
    check(mode_compat == 1'b1, "R1 compat bit", mode_compat, 1);
    wr_reg(8'h3F, 8'h00);
    rd_reg(8'h3E, 8'hA0, "R1 other addr write ignored");
    rd_reg(8'h3F, 8'h00, "R1 other addr reads zero");
    wr_reg(8'h3E, 8'h80);
    rd_reg(8'h3E, 8'h80, "R1 restore");

    // M1 enabled: R4, R10, R9 (no replay with enable set)
    bench_m1e = 1;
    do_cyc(2'b00, 16'h0010, 0, "R4 fetch m1 low");
    do_cyc(2'b00, 16'h0011, 0, "R10 R9 back-to-back no replay");
    do_cyc(2'b01, 16'h0005, 0, "R3 R4 memory read");
    do_cyc(2'b10, 16'h0000, 0, "R5 int ack");
    do_cyc(2'b11, 16'h0066, 0, "R5 nmi ack");
    settle();

    // M1 suppressed
    wr_reg(8'h3E, 8'h00);
    bench_m1e = 0;
    rd_reg(8'h3E, 8'h00, "R1 enable cleared");
    do_cyc(2'b00, 16'h0002, 0, "R6 fetch m1 high");
    do_cyc(2'b10, 16'h0000, 0, "R5 int ack with enable clear");
    do_cyc(2'b00, 16'h0010, 0, "R7 prefix fetch");
    do_cyc(2'b00, 16'h0011, 1, "R7 R8 return fetch");
    do_cyc(2'b00, 16'h0012, 0, "R8 next fetch after replay");
    do_cyc(2'b00, 16'h0020, 0, "R9 prefix");
    do_cyc(2'b00, 16'h0021, 0, "R9 other second byte");
    do_cyc(2'b00, 16'h0030, 0, "R9 prefix");
    do_cyc(2'b00, 16'h0040, 0, "R9 non-adjacent 4D");
    do_cyc(2'b00, 16'h0050, 0, "R9 prefix");
    do_cyc(2'b01, 16'h0060, 0, "R9 data read between");
    do_cyc(2'b00, 16'h0051, 0, "R9 4D after data read");
    settle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule